// File: doc/BRIEF.md
# Dual-CPU Shared RAM Arbiter

This block sits between a slow host 8-bit CPU, a faster 65xx-style coprocessor and one synchronous RAM of 64 KB. The RAM is divided into eight 8 KB pages. The host sees one page at a time through an 8 KB window in its own memory map. A host-writable bank register picks that page, so the host can load programs and data into the coprocessor's memory and read results back from it.

The host also sets the coprocessor's run mode through a control register. The modes are stopped, free-running, locked to the host's phi2 cycle, single-step and held in reset. The host always has priority on the RAM port.

The design runs on one fast clock and samples the host bus synchronously. The host's phi2 is an ordinary input level on that clock. The coprocessor bus uses a request/ready handshake. The coprocessor raises `cop_req` with its address, direction and write data, and holds all of them stable until it samples `cop_ready` high on a clock edge. That edge is the granted bus cycle. Write data is stored at that edge. Read data appears on `cop_rdata` one clock later. While `cop_ready` is low the coprocessor is back-pressured and must hold its request unchanged.

Top module: `shram_arbiter`

## Requirements
- R1: After reset, the control register (register select 0) and the bank register (register select 1) both read 0. `cop_rst_n` is high and `cop_ready` stays low even while `cop_req` is held high, because mode 0 is stop.
- R2: A host window access maps host offset `host_addr[12:0]` to RAM address {bank[2:0], host_addr[12:0]}. A write stores the data there. A read returns that byte on `host_rdata` one clock after the access starts.
- R3: The bank register keeps only data bits [2:0]. The control register keeps only data bits [2:0]. Both read back zero-extended to 8 bits, and register select 2 reads 0.
- R4: A host window access (`host_phi2` high and `host_win_sel` high) always owns the RAM port. In every such cycle `cop_ready` is low.
- R5: In mode 1 (free-run), a pending coprocessor request is granted in every clock cycle without a host window access. A granted write is stored at `cop_addr`, and the host can read it back through the window.
- R6: In mode 2 (sync), the coprocessor gets exactly one granted cycle per rising edge of `host_phi2` while it keeps requesting. This holds even when the host uses the window during phi2 high.
- R7: In mode 3 (step), no cycle is granted until the host writes register select 2. Each such write grants exactly one cycle.
- R8: In mode 4 (reset), `cop_rst_n` is low and no cycle is granted. In every other mode `cop_rst_n` is high.
- R9: Modes 0, 5, 6 and 7 grant no coprocessor cycles. A control register write clears any credit left from sync or step mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_phi2 | input | 1 | Host phi2 level; accesses happen while high |
| host_win_sel | input | 1 | Host address decodes to the 8 KB window |
| host_reg_sel | input | 1 | Host address decodes to the register block |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 13 | Window offset; bits [1:0] pick a register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| cop_req | input | 1 | Coprocessor request valid |
| cop_wr | input | 1 | 1 = coprocessor write |
| cop_addr | input | 16 | Coprocessor address |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_ready | output | 1 | Request granted this cycle |
| cop_rdata | output | 8 | Coprocessor read data, one cycle after grant |
| cop_rst_n | output | 1 | Coprocessor reset, active low |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle latency |

## Verification
The hardest case is sync mode while the host also uses the window. Here the one-per-phi2 credit has to survive a phi2-high phase in which the host blocks the port, and then be spent in the low phase. The bench builds this case by holding a coprocessor read request high throughout. It then runs a series of host cycles with random window writes and counts grants against the number of phi2 rising edges.

Single-step credit is exercised in a similar way. The bench idles with the request pending, then issues step strobes one at a time and checks that each strobe yields exactly one grant.

// File: rtl/shram_pkg.sv
package shram_pkg;
  typedef enum logic [2:0] {
    MODE_STOP  = 3'd0,
    MODE_FREE  = 3'd1,
    MODE_SYNC  = 3'd2,
    MODE_STEP  = 3'd3,
    MODE_RESET = 3'd4
  } cop_mode_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BANK = 2'd1;
  localparam logic [1:0] SEL_STEP = 2'd2;
endpackage

// File: rtl/shram_host_regs.sv
module shram_host_regs
  import shram_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [2:0]        mode,
  output logic [PAGE_W-1:0] bank,
  output logic              mode_wr,
  output logic              step_pulse,
  output logic [DATA_W-1:0] rdata
);
  logic step_q;
  logic step_now;
  wire  unused_wdata = ^wdata;

  assign step_now   = wr_en && (sel == SEL_STEP);
  assign step_pulse = step_now && !step_q;
  assign mode_wr    = wr_en && (sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= 3'd0;
      bank   <= '0;
      step_q <= 1'b0;
    end else begin
      step_q <= step_now;
      if (wr_en && sel == SEL_CTRL) mode <= wdata[2:0];
      if (wr_en && sel == SEL_BANK) bank <= wdata[PAGE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL: rdata[2:0]        = mode;
      SEL_BANK: rdata[PAGE_W-1:0] = bank;
      default:  rdata             = '0;
    endcase
  end

  // R7
  step_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);
endmodule

// File: rtl/shram_cop_gate.sv
module shram_cop_gate
  import shram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       mode_wr,
  input  logic       step_pulse,
  input  logic       phi2,
  input  logic       host_busy,
  input  logic       cop_req,
  output logic       cop_ready,
  output logic       cop_rst_n
);
  logic phi2_q, rise, credit, allowed;
  logic got_since_rise;

  assign rise = phi2 && !phi2_q;

  always_comb begin
    case (cop_mode_e'(mode))
      MODE_FREE:            allowed = 1'b1;
      MODE_SYNC, MODE_STEP: allowed = credit;
      default:              allowed = 1'b0;
    endcase
  end

  assign cop_ready = cop_req && allowed && !host_busy;
  assign cop_rst_n = (mode != MODE_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phi2_q <= 1'b0;
      credit <= 1'b0;
    end else begin
      phi2_q <= phi2;
      if (mode_wr)
        credit <= 1'b0;
      else if ((mode == MODE_SYNC && rise) || (mode == MODE_STEP && step_pulse))
        credit <= 1'b1;
      else if (cop_ready)
        credit <= 1'b0;
    end
  end

  // checker state: grant seen since the last phi2 rise
  always_ff @(posedge clk) begin
    if (!rst_n)         got_since_rise <= 1'b0;
    else if (rise)      got_since_rise <= cop_ready;
    else if (cop_ready) got_since_rise <= 1'b1;
  end

  // R4
  host_blocks_cop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> !cop_ready);
  // R6
  sync_one_per_phi2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SYNC && got_since_rise && !rise) |-> !cop_ready);
  // R7
  step_one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STEP && cop_ready) |=> !cop_ready);
  // R8
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RESET) |-> (!cop_rst_n && !cop_ready));
  // R9
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP || mode > MODE_RESET) |-> !cop_ready);
endmodule

// File: rtl/shram_port_mux.sv
module shram_port_mux #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int OFF_W = ADDR_W - PAGE_W
) (
  input  logic              host_busy,
  input  logic              host_wr,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [PAGE_W-1:0] bank,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              cop_grant,
  input  logic              cop_wr,
  input  logic [ADDR_W-1:0] cop_addr,
  input  logic [DATA_W-1:0] cop_wdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = cop_addr;
    ram_wdata = cop_wdata;
    if (host_busy) begin
      ram_en    = 1'b1;
      ram_we    = host_wr;
      ram_addr  = {bank, host_off};
      ram_wdata = host_wdata;
    end else if (cop_grant) begin
      ram_en = 1'b1;
      ram_we = cop_wr;
    end
  end
endmodule

// File: rtl/shram_arbiter.sv
module shram_arbiter #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int OFF_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_phi2,
  input  logic              host_win_sel,
  input  logic              host_reg_sel,
  input  logic              host_wr,
  input  logic [OFF_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cop_req,
  input  logic              cop_wr,
  input  logic [ADDR_W-1:0] cop_addr,
  input  logic [DATA_W-1:0] cop_wdata,
  output logic              cop_ready,
  output logic [DATA_W-1:0] cop_rdata,
  output logic              cop_rst_n,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  logic              host_busy, reg_wr, mode_wr, step_pulse;
  logic [2:0]        mode;
  logic [PAGE_W-1:0] bank;
  logic [DATA_W-1:0] reg_rdata;

  assign host_busy = host_phi2 && host_win_sel;
  assign reg_wr    = host_phi2 && host_reg_sel && host_wr;

  shram_host_regs #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(host_addr[1:0]),
    .wdata(host_wdata), .mode(mode), .bank(bank), .mode_wr(mode_wr),
    .step_pulse(step_pulse), .rdata(reg_rdata));

  shram_cop_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mode_wr(mode_wr),
    .step_pulse(step_pulse), .phi2(host_phi2), .host_busy(host_busy),
    .cop_req(cop_req), .cop_ready(cop_ready), .cop_rst_n(cop_rst_n));

  shram_port_mux #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_mux (
    .host_busy(host_busy), .host_wr(host_wr), .host_off(host_addr),
    .bank(bank), .host_wdata(host_wdata), .cop_grant(cop_ready),
    .cop_wr(cop_wr), .cop_addr(cop_addr), .cop_wdata(cop_wdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata));

  assign host_rdata = host_reg_sel ? reg_rdata : ram_rdata;
  assign cop_rdata  = ram_rdata;

  // R2
  host_window_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> (ram_en && ram_we == host_wr &&
                   ram_addr[ADDR_W-1:OFF_W] == bank &&
                   ram_addr[OFF_W-1:0] == host_addr));
  // R5
  cop_port_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_ready |-> (ram_en && ram_addr == cop_addr && ram_we == cop_wr));
endmodule

// File: tb/shram_arbiter_tb.sv
module shram_arbiter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_phi2 = 0, host_win_sel = 0, host_reg_sel = 0, host_wr = 0;
  logic [12:0] host_addr = '0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic cop_req = 0, cop_wr = 0, cop_ready, cop_rst_n;
  logic [15:0] cop_addr = '0;
  logic [7:0]  cop_wdata = '0, cop_rdata;
  logic ram_en, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata = '0;

  int checks = 0, fails = 0, gcnt = 0;
  logic [7:0] mem [int unsigned];
  logic [7:0] expct [int unsigned];

  always #2 clk = ~clk;

  shram_arbiter u_dut (.*);

  always @(posedge clk) if (ram_en) begin
    if (ram_we) mem[ram_addr] = ram_wdata;
    else ram_rdata <= mem.exists(ram_addr) ? mem[ram_addr] : 8'h00;
  end

  always @(negedge clk) if (cop_req && cop_ready) gcnt++;

  function automatic logic [15:0] map_addr(input logic [2:0] pg, input logic [12:0] off);
    return {pg, off};
  endfunction
  function automatic logic [7:0] reg_view(input logic [7:0] v);
    return {5'b0, v[2:0]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_cycle(input logic win, input logic rsel, input logic wr,
                            input logic [12:0] a, input logic [7:0] d,
                            output logic [7:0] rd);
    @(posedge clk); #1;
    host_phi2 = 1; host_win_sel = win; host_reg_sel = rsel;
    host_wr = wr; host_addr = a; host_wdata = d;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd = host_rdata;
    @(posedge clk); #1;
    host_phi2 = 0; host_win_sel = 0; host_reg_sel = 0; host_wr = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [7:0] d);
    logic [7:0] junk;
    host_cycle(0, 1, 1, {11'b0, s}, d, junk);
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [7:0] d);
    host_cycle(0, 1, 0, {11'b0, s}, 8'h00, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    cop_req = 1; cop_wr = 0; cop_addr = 16'h0100;
    gcnt = 0;
    idle(10);
    check("R1 stop grants", gcnt, 0);
    check("R1 cop_rst_n", cop_rst_n, 1);
    reg_rd(0, rd); check("R1 ctrl reset", rd, 0);
    reg_rd(1, rd); check("R1 bank reset", rd, 0);
    cop_req = 0;

    // R3 register masking
    reg_wr(1, 8'hFF); reg_rd(1, rd); check("R3 bank mask", rd, reg_view(8'hFF));
    reg_rd(2, rd); check("R3 strobe reads 0", rd, 0);

    // R2 random window traffic
    for (int i = 0; i < 40; i++) begin
      logic [2:0] pg; logic [12:0] off; logic [7:0] d;
      pg = 3'($urandom); off = 13'($urandom); d = 8'($urandom);
      if (i < 2) off = (i == 0) ? 13'h0000 : 13'h1FFF;
      reg_wr(1, {5'($urandom), pg});
      host_cycle(1, 0, 1, off, d, rd);
      expct[map_addr(pg, off)] = d;
      check("R2 write lands", mem.exists(map_addr(pg, off)) ? int'(mem[map_addr(pg, off)]) : -1, d);
    end
    foreach (expct[a]) begin
      reg_wr(1, 8'(a >> 13));
      host_cycle(1, 0, 0, 13'(a), 8'h00, rd);
      check("R2 read back", rd, expct[a]);
    end

    // R5 free-run
    reg_wr(0, 8'd1);
    gcnt = 0; cop_req = 1; idle(20);
    check("R5 free grants", gcnt, 20);
    cop_req = 0;
    @(posedge clk); #1;
    cop_req = 1; cop_wr = 1; cop_addr = 16'hA5C3; cop_wdata = 8'h3C;
    @(posedge clk); #1; cop_req = 0; cop_wr = 0;
    reg_wr(1, 8'h05);
    host_cycle(1, 0, 0, 13'h05C3, 8'h00, rd);
    check("R5 cop write visible to host", rd, 8'h3C);

    // R4 host priority in free mode
    cop_req = 1; cop_addr = 16'h0200;
    @(posedge clk); #1;
    host_phi2 = 1; host_win_sel = 1; host_wr = 0; host_addr = 13'h10;
    gcnt = 0; idle(6);
    check("R4 no grant under host", gcnt, 0);
    host_phi2 = 0; host_win_sel = 0;
    idle(4);
    check("R4 grants resume", gcnt, 4);

    // R6 sync, with window writes mixed in
    reg_wr(0, 8'd0);
    reg_wr(0, 8'd2);
    cop_req = 1; cop_wr = 0; gcnt = 0;
    for (int k = 0; k < 10; k++) begin
      logic w;
      w = 1'($urandom);
      host_cycle(w, 0, 1, 13'($urandom), 8'($urandom), rd);
    end
    check("R6 one grant per phi2", gcnt, 10);
    cop_req = 0;

    // R7 step
    reg_wr(0, 8'd3);
    cop_req = 1; gcnt = 0; idle(20);
    check("R7 no strobe no grant", gcnt, 0);
    reg_wr(2, 8'h00);
    check("R7 one strobe", gcnt, 1);
    reg_wr(2, 8'h00); reg_wr(2, 8'h00); reg_wr(2, 8'h00);
    idle(10);
    check("R7 three more strobes", gcnt, 4);

    // R8 reset mode
    reg_wr(0, 8'd4);
    gcnt = 0; idle(10);
    check("R8 cop_rst_n low", cop_rst_n, 0);
    check("R8 no grants", gcnt, 0);
    reg_rd(0, rd); check("R8 ctrl readback", rd, 4);

    // R9 spare mode and credit clearing
    reg_wr(0, 8'hFD);
    gcnt = 0; idle(10);
    reg_rd(0, rd); check("R9 ctrl readback masked", rd, reg_view(8'hFD));
    check("R9 spare mode no grants", gcnt, 0);
    check("R8 rst_n high outside reset", cop_rst_n, 1);
    cop_req = 0;
    reg_wr(0, 8'd3); reg_wr(2, 8'h00);
    reg_wr(0, 8'd3);
    cop_req = 1; gcnt = 0; idle(10);
    check("R9 ctrl write clears credit", gcnt, 0);
    cop_req = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule